// File: doc/BRIEF.md
# SCL Phase Timing Generator

This block times the clock phases of an I2C master. A bus engine asks for an SCL high phase, an SCL low phase or a repeated-start setup delay. The block counts the programmed length of that interval and then reports, with a one-cycle pulse, that the interval has ended. The phase output of the last request stays asserted after it ends, so the pad logic can keep SCL in that level until the engine asks for the next phase.

The length comes from a three-stage cascade. A divider turns the source clock into a divided clock. A sample prescaler turns divided-clock cycles into sample ticks. A step counter counts sample ticks. Every programmed field holds its count minus one. A high or low phase therefore lasts (div+1)·(sample+1)·(step+1) source cycles. The setup delay skips the sample stage and counts divided-clock cycles directly.

Two field sets exist: one for standard and fast speeds, and one for high-speed transfers. A mode input chooses between them. The choice and all selected fields are captured when a request is accepted, so a timed interval is never disturbed by register writes.

Top module: `scl_phase_timer`

## Requirements
- R1: After reset, scl_high_o, scl_low_o, all three done pulses, busy_o and hs_active_o are 0.
- R2: In normal mode, a high request that is accepted ends with high_done_o N cycles after the accepting edge. N = (clkdiv[7:0]+1)·(htime[10:8]+1)·(htime[5:0]+1).
- R3: In normal mode, a low request ends with low_done_o after (clkdiv[7:0]+1)·(ltime[8:6]+1)·(ltime[5:0]+1) cycles.
- R4: In high-speed mode, the divider is clkdiv[15:8]. The high phase uses hsreg[14:12] as sample and hsreg[10:8] as step. The low phase uses ltime[14:12] as sample and ltime[11:9] as step.
- R5: A setup request with ext[0]=1 ends with setup_done_o after (div+1)·(count+1) cycles, where count is ext[15:8] in normal mode and ext[7:1] in high-speed mode. With ext[0]=0 it ends after 1 cycle.
- R6: Done pulses last one cycle, and only the pulse of the requested kind fires. From the cycle after acceptance, a high request sets scl_high_o and clears scl_low_o. A low request does the reverse, and a setup request clears both. The level holds after the done pulse until the next accepted request or a stop.
- R7: Requests arriving while busy_o=1 are ignored. They change neither the latency nor the phase outputs.
- R8: hs_mode_i is sampled only at acceptance. Toggling it during an interval has no effect, and hs_active_o shows the captured mode.
- R9: stop_i aborts an interval without any done pulse. On the next cycle busy_o and both phase outputs are 0. stop_i also blocks a request in the same cycle.
- R10: When several requests arrive together while idle, setup wins over low, and low wins over high.
- R11: Register changes during an interval do not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | source clock |
| rst_ni | input | 1 | active-low synchronous reset |
| clkdiv_reg_i | input | 16 | dividers: [7:0] normal, [15:8] high-speed |
| htime_reg_i | input | 16 | normal high phase: sample [10:8], step [5:0] |
| ltime_reg_i | input | 16 | low phase: normal sample [8:6] and step [5:0]; high-speed sample [14:12] and step [11:9] |
| ext_reg_i | input | 16 | setup: enable [0], normal count [15:8], high-speed count [7:1] |
| hs_reg_i | input | 16 | high-speed high phase: sample [14:12], step [10:8] |
| hs_mode_i | input | 1 | selects the high-speed field set at acceptance |
| req_high_i | input | 1 | request an SCL high phase |
| req_low_i | input | 1 | request an SCL low phase |
| req_setup_i | input | 1 | request a start-setup delay |
| stop_i | input | 1 | abort and clear phase outputs |
| scl_high_o | output | 1 | high phase level |
| scl_low_o | output | 1 | low phase level |
| high_done_o | output | 1 | high phase ended (one cycle) |
| low_done_o | output | 1 | low phase ended (one cycle) |
| setup_done_o | output | 1 | setup delay ended (one cycle) |
| busy_o | output | 1 | an interval is being timed |
| hs_active_o | output | 1 | field set captured at last acceptance |

## Verification
Random register contents with small dividers are applied to all three request kinds in both modes. A latency that matches the bench's own product formula therefore separates every field position and the stage each field feeds. Directed cases use asymmetric values (for example sample 1 and step 4 against sample 4 and step 1), so that swapped or misplaced fields show up as a wrong latency. Further directed runs toggle the mode input, rewrite the registers and raise extra requests in the middle of an interval; these tell captured settings apart from live ones. Stop, simultaneous requests and the disabled setup delay are each tried once, to tell abort, priority and the one-cycle shortcut apart.

// File: rtl/scl_tm_pkg.sv
package scl_tm_pkg;
  localparam int unsigned DIV_W  = 8;
  localparam int unsigned SMP_W  = 3;
  localparam int unsigned STEP_W = 8;
  localparam int unsigned REG_W  = 16;

  typedef enum logic [1:0] {OP_NONE, OP_HIGH, OP_LOW, OP_SETUP} op_e;

  // length in source cycles of one interval from its captured limits
  function automatic int unsigned phase_cycles(int unsigned d, int unsigned s,
                                               int unsigned t);
    return (d + 1) * (s + 1) * (t + 1);
  endfunction
endpackage

// File: rtl/scl_tm_arbiter.sv
module scl_tm_arbiter
  import scl_tm_pkg::*;
(
  input  logic idle_i,
  input  logic stop_i,
  input  logic req_high_i,
  input  logic req_low_i,
  input  logic req_setup_i,
  output logic accept_o,
  output op_e  op_o
);
  // fixed priority: setup, then low, then high (R10)
  always_comb begin
    if (req_setup_i)     op_o = OP_SETUP;
    else if (req_low_i)  op_o = OP_LOW;
    else if (req_high_i) op_o = OP_HIGH;
    else                 op_o = OP_NONE;
  end

  // only an idle block accepts, and stop overrides (R7, R9)
  assign accept_o = idle_i && !stop_i && (op_o != OP_NONE);
endmodule

// File: rtl/scl_tm_select.sv
module scl_tm_select
  import scl_tm_pkg::*;
#(
  parameter int unsigned DIV_BITS  = DIV_W,
  parameter int unsigned SMP_BITS  = SMP_W,
  parameter int unsigned STEP_BITS = STEP_W,
  parameter int unsigned REG_BITS  = REG_W
) (
  input  op_e                  op_i,
  input  logic                 hs_i,
  input  logic [REG_BITS-1:0]  clkdiv_i,
  input  logic [REG_BITS-1:0]  htime_i,
  input  logic [REG_BITS-1:0]  ltime_i,
  input  logic [REG_BITS-1:0]  ext_i,
  input  logic [REG_BITS-1:0]  hsreg_i,
  output logic [DIV_BITS-1:0]  div_o,
  output logic [SMP_BITS-1:0]  smp_o,
  output logic [STEP_BITS-1:0] step_o
);
  // field positions that the register layout fixes
  localparam int unsigned N_SMP_LSB_H = 8;   // normal high sample
  localparam int unsigned N_SMP_LSB_L = 6;   // normal low sample
  localparam int unsigned N_STEP_W    = 6;   // normal step width
  localparam int unsigned HS_SMP_LSB  = 12;  // high-speed sample (both regs)
  localparam int unsigned HS_HSTEP_LSB = 8;  // high-speed high step
  localparam int unsigned HS_LSTEP_LSB = 9;  // high-speed low step
  localparam int unsigned HS_STEP_W   = 3;
  localparam int unsigned SU_N_LSB    = 8;   // normal setup count
  localparam int unsigned SU_HS_W     = 7;   // high-speed setup count [7:1]

  logic unused_bits;
  assign unused_bits = ^{htime_i[REG_BITS-1:11], htime_i[7:6], hsreg_i[15],
                         hsreg_i[11], hsreg_i[7:0], ltime_i[15]};

  always_comb begin
    div_o  = hs_i ? clkdiv_i[2*DIV_BITS-1:DIV_BITS] : clkdiv_i[DIV_BITS-1:0];
    smp_o  = '0;
    step_o = '0;
    unique case (op_i)
      OP_HIGH: begin
        if (hs_i) begin
          smp_o  = hsreg_i[HS_SMP_LSB +: SMP_BITS];
          step_o = STEP_BITS'(hsreg_i[HS_HSTEP_LSB +: HS_STEP_W]);
        end else begin
          smp_o  = htime_i[N_SMP_LSB_H +: SMP_BITS];
          step_o = STEP_BITS'(htime_i[0 +: N_STEP_W]);
        end
      end
      OP_LOW: begin
        if (hs_i) begin
          smp_o  = ltime_i[HS_SMP_LSB +: SMP_BITS];
          step_o = STEP_BITS'(ltime_i[HS_LSTEP_LSB +: HS_STEP_W]);
        end else begin
          smp_o  = ltime_i[N_SMP_LSB_L +: SMP_BITS];
          step_o = STEP_BITS'(ltime_i[0 +: N_STEP_W]);
        end
      end
      OP_SETUP: begin
        // raw divided-clock cycles: sample stage bypassed (R5)
        if (!ext_i[0]) begin
          div_o = '0;
        end else if (hs_i) begin
          step_o = STEP_BITS'(ext_i[1 +: SU_HS_W]);
        end else begin
          step_o = STEP_BITS'(ext_i[SU_N_LSB +: 8]);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/scl_tm_cascade.sv
module scl_tm_cascade #(
  parameter int unsigned DIV_BITS  = 8,
  parameter int unsigned SMP_BITS  = 3,
  parameter int unsigned STEP_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 run_i,
  input  logic [DIV_BITS-1:0]  lim_div_i,
  input  logic [SMP_BITS-1:0]  lim_smp_i,
  input  logic [STEP_BITS-1:0] lim_step_i,
  output logic                 div_tick_o,
  output logic                 smp_tick_o,
  output logic                 last_o
);
  logic [DIV_BITS-1:0]  div_q;
  logic [SMP_BITS-1:0]  smp_q;
  logic [STEP_BITS-1:0] step_q;

  assign div_tick_o = run_i && (div_q == lim_div_i);
  assign smp_tick_o = div_tick_o && (smp_q == lim_smp_i);
  assign last_o     = smp_tick_o && (step_q == lim_step_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clear_i || !run_i) begin
      div_q  <= '0;
      smp_q  <= '0;
      step_q <= '0;
    end else begin
      div_q <= div_tick_o ? '0 : div_q + 1'b1;
      if (smp_tick_o)      smp_q <= '0;
      else if (div_tick_o) smp_q <= smp_q + 1'b1;
      if (last_o)          step_q <= '0;
      else if (smp_tick_o) step_q <= step_q + 1'b1;
    end
  end

  // counters never pass their captured limits (R2)
  a_r2_counters_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (div_q <= lim_div_i) && (smp_q <= lim_smp_i) && (step_q <= lim_step_i));
  // a sample tick is always also a divided-clock tick (R2)
  a_r2_tick_nesting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_tick_o |-> div_tick_o);
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_tm_pkg::*;
#(
  parameter int unsigned DIV_BITS  = DIV_W,
  parameter int unsigned SMP_BITS  = SMP_W,
  parameter int unsigned STEP_BITS = STEP_W,
  parameter int unsigned REG_BITS  = REG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [REG_BITS-1:0] clkdiv_reg_i,
  input  logic [REG_BITS-1:0] htime_reg_i,
  input  logic [REG_BITS-1:0] ltime_reg_i,
  input  logic [REG_BITS-1:0] ext_reg_i,
  input  logic [REG_BITS-1:0] hs_reg_i,
  input  logic                hs_mode_i,
  input  logic                req_high_i,
  input  logic                req_low_i,
  input  logic                req_setup_i,
  input  logic                stop_i,
  output logic                scl_high_o,
  output logic                scl_low_o,
  output logic                high_done_o,
  output logic                low_done_o,
  output logic                setup_done_o,
  output logic                busy_o,
  output logic                hs_active_o
);
  localparam int unsigned CNT_BITS = DIV_BITS + SMP_BITS + STEP_BITS + 1;

  // named internal events
  logic                 accept;
  op_e                  req_op;
  logic [DIV_BITS-1:0]  sel_div;
  logic [SMP_BITS-1:0]  sel_smp;
  logic [STEP_BITS-1:0] sel_step;
  logic                 div_tick, smp_tick, last;
  logic                 any_done;

  logic                 busy_q, hs_q, phase_hi_q, phase_lo_q;
  logic                 hdone_q, ldone_q, sdone_q;
  op_e                  op_q;
  logic [DIV_BITS-1:0]  lim_div_q;
  logic [SMP_BITS-1:0]  lim_smp_q;
  logic [STEP_BITS-1:0] lim_step_q;
  logic [CNT_BITS-1:0]  run_cnt_q;

  scl_tm_arbiter u_arb (
    .idle_i      (!busy_q),
    .stop_i      (stop_i),
    .req_high_i  (req_high_i),
    .req_low_i   (req_low_i),
    .req_setup_i (req_setup_i),
    .accept_o    (accept),
    .op_o        (req_op)
  );

  scl_tm_select #(
    .DIV_BITS (DIV_BITS), .SMP_BITS (SMP_BITS),
    .STEP_BITS(STEP_BITS), .REG_BITS (REG_BITS)
  ) u_sel (
    .op_i     (req_op),
    .hs_i     (hs_mode_i),
    .clkdiv_i (clkdiv_reg_i),
    .htime_i  (htime_reg_i),
    .ltime_i  (ltime_reg_i),
    .ext_i    (ext_reg_i),
    .hsreg_i  (hs_reg_i),
    .div_o    (sel_div),
    .smp_o    (sel_smp),
    .step_o   (sel_step)
  );

  scl_tm_cascade #(
    .DIV_BITS (DIV_BITS), .SMP_BITS (SMP_BITS), .STEP_BITS(STEP_BITS)
  ) u_cas (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .run_i      (busy_q),
    .lim_div_i  (lim_div_q),
    .lim_smp_i  (lim_smp_q),
    .lim_step_i (lim_step_q),
    .div_tick_o (div_tick),
    .smp_tick_o (smp_tick),
    .last_o     (last)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      hs_q       <= 1'b0;
      phase_hi_q <= 1'b0;
      phase_lo_q <= 1'b0;
      hdone_q    <= 1'b0;
      ldone_q    <= 1'b0;
      sdone_q    <= 1'b0;
      op_q       <= OP_NONE;
      lim_div_q  <= '0;
      lim_smp_q  <= '0;
      lim_step_q <= '0;
    end else begin
      hdone_q <= 1'b0;
      ldone_q <= 1'b0;
      sdone_q <= 1'b0;
      if (stop_i) begin
        busy_q     <= 1'b0;
        phase_hi_q <= 1'b0;
        phase_lo_q <= 1'b0;
      end else if (accept) begin
        busy_q     <= 1'b1;
        op_q       <= req_op;
        hs_q       <= hs_mode_i;
        lim_div_q  <= sel_div;
        lim_smp_q  <= sel_smp;
        lim_step_q <= sel_step;
        phase_hi_q <= (req_op == OP_HIGH);
        phase_lo_q <= (req_op == OP_LOW);
      end else if (busy_q && last) begin
        busy_q  <= 1'b0;
        hdone_q <= (op_q == OP_HIGH);
        ldone_q <= (op_q == OP_LOW);
        sdone_q <= (op_q == OP_SETUP);
      end
    end
  end

  // cycles spent in the current interval, for the latency check
  always_ff @(posedge clk_i) begin
    if (!rst_ni || accept) run_cnt_q <= '0;
    else if (busy_q)       run_cnt_q <= run_cnt_q + 1'b1;
  end

  assign scl_high_o   = phase_hi_q;
  assign scl_low_o    = phase_lo_q;
  assign high_done_o  = hdone_q;
  assign low_done_o   = ldone_q;
  assign setup_done_o = sdone_q;
  assign busy_o       = busy_q;
  assign hs_active_o  = hs_q;
  assign any_done     = hdone_q || ldone_q || sdone_q;

  // R2 R3 R4 R5: interval length equals the product of captured limits
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_done |-> run_cnt_q == CNT_BITS'(phase_cycles(32'(lim_div_q),
                                         32'(lim_smp_q), 32'(lim_step_q))));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_done |=> !any_done);
  a_r6_done_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hdone_q, ldone_q, sdone_q}));
  a_r6_phase_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_high_o && scl_low_o));
  a_r7_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !stop_i |=> $stable(scl_high_o) && $stable(scl_low_o));
  a_r8_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(hs_active_o));
  a_r9_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_o && !scl_high_o && !scl_low_o && !any_done);
  a_r11_limits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !stop_i |=> $stable(lim_div_q) && $stable(lim_smp_q) &&
                          $stable(lim_step_q));
endmodule

// File: tb/test_scl_phase_timer.sv
module test_scl_phase_timer;
  localparam int K_HIGH = 0, K_LOW = 1, K_SETUP = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] clkdiv_r = '0, htime_r = '0, ltime_r = '0, ext_r = '0, hs_r = '0;
  logic        hs_mode = 1'b0, rq_hi = 1'b0, rq_lo = 1'b0, rq_su = 1'b0, stop = 1'b0;
  logic        scl_high, scl_low, hdone, ldone, sdone, busy, hs_act;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  scl_phase_timer i_scl_phase_timer (
    .clk_i(clk), .rst_ni(rst_n),
    .clkdiv_reg_i(clkdiv_r), .htime_reg_i(htime_r), .ltime_reg_i(ltime_r),
    .ext_reg_i(ext_r), .hs_reg_i(hs_r), .hs_mode_i(hs_mode),
    .req_high_i(rq_hi), .req_low_i(rq_lo), .req_setup_i(rq_su), .stop_i(stop),
    .scl_high_o(scl_high), .scl_low_o(scl_low), .high_done_o(hdone),
    .low_done_o(ldone), .setup_done_o(sdone), .busy_o(busy), .hs_active_o(hs_act)
  );

  function automatic void chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // expected interval length, from the field layout written as arithmetic
  function automatic int unsigned exp_cycles(int kind, bit hs);
    int unsigned d, s, t, c, l, h, e, x;
    c = clkdiv_r; l = ltime_r; h = htime_r; e = ext_r; x = hs_r;
    d = hs ? (c / 256) % 256 : c % 256;
    if (kind == K_SETUP) begin
      if (e % 2 == 0) return 1;
      s = 0;
      t = hs ? (e / 2) % 128 : (e / 256) % 256;
    end else if (kind == K_HIGH) begin
      s = hs ? (x / 4096) % 8 : (h / 256) % 8;
      t = hs ? (x / 256) % 8  : h % 64;
    end else begin
      s = hs ? (l / 4096) % 8 : (l / 64) % 8;
      t = hs ? (l / 512) % 8  : l % 64;
    end
    return (d + 1) * (s + 1) * (t + 1);
  endfunction

  function automatic string tag_of(int kind, bit hs);
    if (kind == K_SETUP) return "R5";
    if (hs) return "R4";
    return (kind == K_HIGH) ? "R2" : "R3";
  endfunction

  // reqmask: bit0 high, bit1 low, bit2 setup; pert 1 = change regs and mode
  // mid-interval, pert 2 = extra requests mid-interval
  task automatic run_op(int kind, bit hs, int reqmask, int pert, string tag);
    int unsigned n;
    int k;
    bit seen;
    logic [2:0] got, want;
    @(negedge clk);
    hs_mode = hs;
    rq_hi = reqmask[0]; rq_lo = reqmask[1]; rq_su = reqmask[2];
    n = exp_cycles(kind, hs);
    @(negedge clk);
    rq_hi = 0; rq_lo = 0; rq_su = 0;
    chk(busy == 1'b1, {tag, " busy after accept"}, busy, 1);
    chk(scl_high == (kind == K_HIGH) && scl_low == (kind == K_LOW),
        {"R6 phase level ", tag}, {scl_high, scl_low}, {kind == K_HIGH, kind == K_LOW});
    chk(hs_act == hs, {"R8 captured mode ", tag}, hs_act, hs);
    k = 0; seen = 0; got = '0;
    while (!seen && k < int'(n) + 8) begin
      @(negedge clk);
      k++;
      if (pert == 1 && k == 1) begin
        hs_mode = !hs;
        clkdiv_r = 16'($urandom); htime_r = 16'($urandom); ltime_r = 16'($urandom);
        ext_r = 16'($urandom); hs_r = 16'($urandom);
      end
      if (pert == 2 && k == 1) begin rq_hi = 1; rq_lo = 1; rq_su = 1; end
      if (pert == 2 && k == 2) begin rq_hi = 0; rq_lo = 0; rq_su = 0; end
      got = {sdone, ldone, hdone};
      if (got != 3'b000) seen = 1;
    end
    want = 3'b001 << kind;
    chk(k == int'(n), {tag, " latency"}, k, n);
    chk(got == want, {"R6 done kind ", tag}, got, want);
    chk(busy == 1'b0, {tag, " idle at done"}, busy, 0);
    @(negedge clk);
    chk({sdone, ldone, hdone} == 3'b000, "R6 done one cycle", {sdone, ldone, hdone}, 0);
    chk(scl_high == (kind == K_HIGH) && scl_low == (kind == K_LOW),
        "R6 phase held after done", {scl_high, scl_low}, {kind == K_HIGH, kind == K_LOW});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk({scl_high, scl_low, hdone, ldone, sdone, busy, hs_act} == 7'b0,
        "R1 reset state", {scl_high, scl_low, hdone, ldone, sdone, busy, hs_act}, 0);

    // R2: normal high, sample 1 step 4 div 2 -> 30
    clkdiv_r = 16'h0002; htime_r = (16'd1 << 8) | 16'd4;
    run_op(K_HIGH, 0, 1, 0, "R2");
    // R2: swapped sample/step must give a different length -> 3*5*2 = 30 too, use 4/1 with div 0
    clkdiv_r = 16'h0000; htime_r = (16'd4 << 8) | 16'd1;
    run_op(K_HIGH, 0, 1, 0, "R2");
    // R3: normal low, sample 2 step 3 div 2 -> 36
    clkdiv_r = 16'h0002; ltime_r = (16'd2 << 6) | 16'd3;
    run_op(K_LOW, 0, 2, 0, "R3");
    // R4: high-speed high and low
    clkdiv_r = 16'h0107; hs_r = (16'd2 << 12) | (16'd3 << 8);
    run_op(K_HIGH, 1, 1, 0, "R4");
    ltime_r = (16'd1 << 12) | (16'd5 << 9) | 16'h003f;
    run_op(K_LOW, 1, 2, 0, "R4");
    // R5: setup counts, both modes, and disabled
    clkdiv_r = 16'h0100; ext_r = (16'd255 << 8) | 16'd1;
    run_op(K_SETUP, 0, 4, 0, "R5");
    ext_r = (16'd9 << 1) | 16'd1;
    run_op(K_SETUP, 1, 4, 0, "R5");
    clkdiv_r = 16'h0303; ext_r = 16'hff00;
    run_op(K_SETUP, 0, 4, 0, "R5 disabled");

    // R8 R11: mode and registers changed mid-interval
    clkdiv_r = 16'h0001; htime_r = (16'd3 << 8) | 16'd5;
    run_op(K_HIGH, 0, 1, 1, "R11 R8");
    clkdiv_r = 16'h0201; ltime_r = (16'd1 << 12) | (16'd2 << 9);
    run_op(K_LOW, 1, 2, 1, "R11 R8");
    // R7: requests while busy
    clkdiv_r = 16'h0001; htime_r = (16'd2 << 8) | 16'd6;
    run_op(K_HIGH, 0, 1, 2, "R7");
    // R10: priority
    ext_r = (16'd4 << 8) | 16'd1; ltime_r = (16'd1 << 6) | 16'd2;
    run_op(K_SETUP, 0, 7, 0, "R10");
    run_op(K_LOW, 0, 3, 0, "R10");

    // R9: stop during an interval
    clkdiv_r = 16'h0303; htime_r = (16'd7 << 8) | 16'd63;
    @(negedge clk); rq_hi = 1;
    @(negedge clk); rq_hi = 0;
    repeat (3) @(negedge clk);
    stop = 1;
    @(negedge clk); stop = 0;
    chk(!busy && !scl_high && !scl_low, "R9 stop clears", {busy, scl_high, scl_low}, 0);
    begin
      int pulses = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (hdone || ldone || sdone) pulses++;
      end
      chk(pulses == 0, "R9 no done after stop", pulses, 0);
    end
    // R9: stop blocks a simultaneous request
    @(negedge clk); stop = 1; rq_lo = 1;
    @(negedge clk); stop = 0; rq_lo = 0;
    chk(!busy && !scl_low, "R9 stop beats request", {busy, scl_low}, 0);

    // random mix
    for (int i = 0; i < 30; i++) begin
      int kind;
      bit hs;
      kind = int'($urandom % 3);
      hs = 1'($urandom % 2);
      clkdiv_r = {8'($urandom % 4), 8'($urandom % 4)};
      htime_r = 16'($urandom); ltime_r = 16'($urandom);
      ext_r = 16'($urandom); hs_r = 16'($urandom);
      run_op(kind, hs, 1 << kind, 0, tag_of(kind, hs));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule